// File: doc/BRIEF.md
# Two-wire bus stuck-low recovery controller

This block supervises the clock and data lines of a two-wire bus whose upstream segment is switched onto several downstream channels. Each channel has its own enable input, and any set of channels may be joined to the upstream bus at once. The block receives line levels that are already sampled and synchronised. It drives one connect control and one open-drain clock pull-low control per channel, plus a fault flag.

While the detection input is high, a window timer measures how long the upstream lines have gone without being high together. The timer restarts in every cycle in which clock and data are both sampled high. If the timer reaches its limit, the block takes these actions:
- It raises the fault flag.
- It cuts every channel from the upstream bus.
- It drives a bounded train of clock pulses onto the enabled channels, so that a device holding data low can finish its byte and let go.

The pulse train ends early if the downstream data line is seen released. The connections come back only after the upstream lines are seen idle. The window length is given in milliseconds and is turned into a cycle count from the clock rate.

Top module: `twb_stuck_recovery`

## Requirements
- R1: While `stuck_flag` is 0, `link_on[i]` equals `chan_en[i]` for every channel, for all 16 enable patterns. While `stuck_flag` is 1, every bit of `link_on` is 0.
- R2: With `detect_en` high, `stuck_flag` rises after the WIN_CYC-th consecutive clock edge at which `scl_in` and `sda_in` are not both 1, and not before. WIN_CYC = CLK_KHZ * WINDOW_MS.
- R3: A single edge at which `scl_in` and `sda_in` are both 1 restarts the window. One line high on its own does not restart it.
- R4: While `detect_en` is 0, no fault is raised. If `detect_en` drops during an episode, then one edge later `stuck_flag` is 0, `clk_pull` is 0 and `link_on` follows `chan_en`.
- R5: In the first cycle of a fault, `clk_pull` equals `chan_en`. Each pulse pulls low (bit = 1) for HALF_CYC cycles and then releases for HALF_CYC cycles. Pulses appear only on enabled channels.
- R6: An episode contains at most MAX_PULSES (default 16) pull-low pulses.
- R7: If `sda_down` is 1 at an edge during a release half, no further pulse starts.
- R8: After the pulse train ends, `stuck_flag` stays 1 and the links stay cut until an edge at which `scl_in` and `sda_in` are both 1. One edge after that, `stuck_flag` is 0 and `link_on` equals `chan_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled upstream clock line level |
| sda_in | input | 1 | Sampled upstream data line level |
| sda_down | input | 1 | Sampled downstream data line level |
| detect_en | input | 1 | Enables detection and recovery |
| chan_en | input | NCH | Per-channel connect request |
| link_on | output | NCH | Per-channel connect control |
| clk_pull | output | NCH | Per-channel clock pull-low control (1 = pull low) |
| stuck_flag | output | 1 | Stuck-low fault indication |

## Verification
The hardest situation to reach from the ports is the end of a recovery episode, where the release of the downstream data line races the pulse counter. The bench reaches it by raising `sda_down` at the moment it observes the N-th pull-low pulse begin. This places the release inside a pull phase, which must be ignored until the following release half. It repeats this for several N and enable patterns and compares the observed pulse count and the number of pulled-low cycles with N. A run with no release exercises the 16-pulse ceiling, and separate window tests restart the timer one edge before expiry.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [1:0] {
    ST_WATCH  = 2'd0,
    ST_PULSE  = 2'd1,
    ST_SETTLE = 2'd2
  } rec_state_e;
endpackage

// File: rtl/twb_window_timer.sv
module twb_window_timer #(
  parameter int unsigned WIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic both_high,
  output logic expired
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign expired = run && !both_high && at_last;

  always_comb begin
    if (!run || both_high) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/twb_pulse_train.sv
module twb_pulse_train #(
  parameter int unsigned HALF_CYC   = 625,
  parameter int unsigned MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic data_free,
  output logic pull,
  output logic done
);
  localparam int unsigned PW = $clog2(HALF_CYC + 1);
  localparam int unsigned NW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);
  localparam logic [NW-1:0] N_LAST  = NW'(MAX_PULSES - 1);

  logic [PW-1:0] ph_q, ph_d;
  logic [NW-1:0] num_q, num_d;
  logic          pull_q, pull_d;
  logic          half_end;

  assign half_end = (ph_q == PH_LAST);
  assign pull     = pull_q;
  assign done     = active && !pull_q &&
                    (data_free || (half_end && num_q == N_LAST));

  always_comb begin
    ph_d   = ph_q;
    num_d  = num_q;
    pull_d = pull_q;
    if (start) begin
      ph_d   = '0;
      num_d  = '0;
      pull_d = 1'b1;
    end else if (active) begin
      if (half_end) begin
        ph_d   = '0;
        pull_d = !pull_q;
        if (!pull_q) num_d = num_q + 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end else begin
      pull_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      num_q  <= '0;
      pull_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      num_q  <= num_d;
      pull_q <= pull_d;
    end
  end
endmodule

// File: rtl/twb_stuck_recovery.sv
module twb_stuck_recovery
  import twb_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned CLK_KHZ    = 125000,
  parameter int unsigned WINDOW_MS  = 45,
  parameter int unsigned HALF_CYC   = 625,
  parameter int unsigned MAX_PULSES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_in,
  input  logic           sda_in,
  input  logic           sda_down,
  input  logic           detect_en,
  input  logic [NCH-1:0] chan_en,
  output logic [NCH-1:0] link_on,
  output logic [NCH-1:0] clk_pull,
  output logic           stuck_flag
);
  localparam int unsigned WIN_CYC = CLK_KHZ * WINDOW_MS;

  rec_state_e state_q, state_d;
  logic both_high, expired, start, active, pull, done, cut;

  assign both_high = scl_in && sda_in;
  assign start     = (state_q == ST_WATCH) && expired;
  assign active    = (state_q == ST_PULSE);
  assign cut       = (state_q != ST_WATCH);

  twb_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (detect_en && state_q == ST_WATCH),
    .both_high (both_high),
    .expired   (expired)
  );

  twb_pulse_train #(.HALF_CYC(HALF_CYC), .MAX_PULSES(MAX_PULSES)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .active    (active),
    .data_free (sda_down),
    .pull      (pull),
    .done      (done)
  );

  always_comb begin
    state_d = state_q;
    if (!detect_en) begin
      state_d = ST_WATCH;
    end else begin
      unique case (state_q)
        ST_WATCH:  if (expired)   state_d = ST_PULSE;
        ST_PULSE:  if (done)      state_d = ST_SETTLE;
        ST_SETTLE: if (both_high) state_d = ST_WATCH;
        default:                  state_d = ST_WATCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WATCH;
    else        state_q <= state_d;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign link_on[i]  = chan_en[i] && !cut;
    assign clk_pull[i] = chan_en[i] && active && pull;
  end

  assign stuck_flag = cut;
endmodule

// File: rtl/twb_stuck_recovery_chk.sv
module twb_stuck_recovery_chk #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned MAX_PULSES = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           scl_in,
  input logic           sda_in,
  input logic           detect_en,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] link_on,
  input logic [NCH-1:0] clk_pull,
  input logic           stuck_flag
);
  localparam int unsigned CW = $clog2(MAX_PULSES + 2) + 1;

  logic [CW-1:0] seen_q;
  logic          prev_q;
  logic          any_pull;

  assign any_pull = |clk_pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= any_pull;
      if (!stuck_flag)              seen_q <= '0;
      else if (any_pull && !prev_q) seen_q <= seen_q + 1'b1;
    end
  end

  a_r1_links_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !stuck_flag |-> (link_on == chan_en));
  a_r1_links_cut: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_flag |-> (link_on == '0));
  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck_flag) |-> ($past(detect_en) && !$past(scl_in && sda_in)));
  a_r4_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !detect_en |=> !stuck_flag);
  a_r5_pull_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_pull & ~chan_en) == '0);
  a_r5_pull_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    any_pull |-> stuck_flag);
  a_r6_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= CW'(MAX_PULSES));
  a_r8_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stuck_flag) |-> (!$past(detect_en) || $past(scl_in && sda_in)));
endmodule

bind twb_stuck_recovery twb_stuck_recovery_chk #(
  .NCH(NCH), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
  .detect_en(detect_en), .chan_en(chan_en), .link_on(link_on),
  .clk_pull(clk_pull), .stuck_flag(stuck_flag)
);

// File: tb/sim_twb_stuck_recovery.sv
`timescale 1ns/1ps
module sim_twb_stuck_recovery;
  localparam int NCH  = 4;
  localparam int KHZ  = 4;
  localparam int MS   = 5;
  localparam int LIM  = KHZ * MS;
  localparam int HALF = 3;
  localparam int MAXP = 16;

  // fields: [13:10] enables, [9:5] release after pulse N (0 = never), [4:0] expected pulses
  localparam logic [13:0] VEC [4] = '{
    {4'b1111, 5'd0, 5'd16},
    {4'b0101, 5'd3, 5'd3},
    {4'b1000, 5'd1, 5'd1},
    {4'b0110, 5'd7, 5'd7}
  };

  logic clk = 1'b0, rst_n;
  logic scl_in, sda_in, sda_down, detect_en;
  logic [NCH-1:0] chan_en, link_on, clk_pull;
  logic stuck_flag;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  twb_stuck_recovery #(.NCH(NCH), .CLK_KHZ(KHZ), .WINDOW_MS(MS),
                       .HALF_CYC(HALF), .MAX_PULSES(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_down(sda_down), .detect_en(detect_en), .chan_en(chan_en),
    .link_on(link_on), .clk_pull(clk_pull), .stuck_flag(stuck_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm(input logic s, input logic d, input logic [NCH-1:0] en);
    @(negedge clk);
    detect_en = 1'b0;
    @(negedge clk);
    detect_en = 1'b1;
    scl_in = s; sda_in = d; sda_down = 1'b0; chan_en = en;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; sda_down = 1'b0;
    detect_en = 1'b0; chan_en = 4'b1011;
    repeat (3) @(negedge clk);
    chk(stuck_flag == 1'b0, "R1 reset fault", stuck_flag, 0);
    chk(link_on == chan_en, "R1 reset links", link_on, chan_en);
    rst_n = 1'b1;

    // recovery episodes from the vector table
    foreach (VEC[k]) begin
      logic [NCH-1:0] en;
      int n_rel, n_exp, rises, lows, stray;
      bit prev;
      en = VEC[k][13:10]; n_rel = VEC[k][9:5]; n_exp = VEC[k][4:0];
      arm(1'b0, 1'b0, en);
      repeat (LIM - 1) @(negedge clk);
      chk(stuck_flag == 1'b0, "R2 no early fault", stuck_flag, 0);
      @(negedge clk);
      chk(stuck_flag == 1'b1, "R2 fault at window end", stuck_flag, 1);
      chk(link_on == '0, "R1 links cut", link_on, 0);
      chk(clk_pull == en, "R5 first pull", clk_pull, en);
      rises = 1; lows = 1; stray = 0; prev = 1'b1;
      if (n_rel == 1) sda_down = 1'b1;
      repeat (MAXP * 2 * HALF + 14) begin
        @(negedge clk);
        if ((clk_pull & ~en) != '0) stray++;
        if (clk_pull != '0) lows++;
        if (clk_pull != '0 && !prev) begin
          rises++;
          if (rises == n_rel) sda_down = 1'b1;
        end
        prev = (clk_pull != '0);
      end
      chk(rises == n_exp, "R6 R7 pulse count", rises, n_exp);
      chk(lows == n_exp * HALF, "R5 pulled cycles", lows, n_exp * HALF);
      chk(stray == 0, "R5 disabled channel pulsed", stray, 0);
      chk(stuck_flag == 1'b1, "R8 fault held", stuck_flag, 1);
      scl_in = 1'b1;
      @(negedge clk);
      chk(stuck_flag == 1'b1, "R8 clock alone not idle", stuck_flag, 1);
      sda_in = 1'b1;
      @(negedge clk);
      chk(stuck_flag == 1'b0, "R8 fault cleared", stuck_flag, 0);
      chk(link_on == en, "R8 links restored", link_on, en);
    end

    // R1: every enable pattern while idle
    for (int p = 0; p < 16; p++) begin
      chan_en = p[NCH-1:0];
      #1;
      chk(link_on == chan_en, "R1 link pattern", link_on, chan_en);
    end

    // R3: restart one edge before expiry
    arm(1'b0, 1'b0, 4'b1111);
    repeat (LIM - 1) @(negedge clk);
    scl_in = 1'b1; sda_in = 1'b1;
    @(negedge clk);
    scl_in = 1'b0; sda_in = 1'b0;
    repeat (LIM - 1) @(negedge clk);
    chk(stuck_flag == 1'b0, "R3 window restarted", stuck_flag, 0);
    @(negedge clk);
    chk(stuck_flag == 1'b1, "R3 fault after restart", stuck_flag, 1);

    // R3: clock high alone does not restart
    arm(1'b1, 1'b0, 4'b0011);
    repeat (LIM) @(negedge clk);
    chk(stuck_flag == 1'b1, "R3 single line no restart", stuck_flag, 1);

    // R4: detection disabled
    @(negedge clk);
    detect_en = 1'b0; scl_in = 1'b0; sda_in = 1'b0; chan_en = 4'b1001;
    repeat (3 * LIM) @(negedge clk);
    chk(stuck_flag == 1'b0, "R4 no fault when disabled", stuck_flag, 0);
    chk(link_on == chan_en, "R4 links follow", link_on, chan_en);

    // R4: abort mid-episode
    arm(1'b0, 1'b0, 4'b1110);
    repeat (LIM + 2) @(negedge clk);
    chk(stuck_flag == 1'b1, "R4 episode running", stuck_flag, 1);
    detect_en = 1'b0;
    @(negedge clk);
    chk(stuck_flag == 1'b0, "R4 abort fault", stuck_flag, 0);
    chk(clk_pull == '0, "R4 abort pulls", clk_pull, 0);
    chk(link_on == chan_en, "R4 abort links", link_on, chan_en);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule